// File: doc/BRIEF.md
# Load/Store Multiple Transfer Sequencer

This block turns one block-transfer request into a series of single-word memory accesses. It takes a base address, a 16-bit register-selection mask and three mode bits: pre or post increment, base writeback, and load or store. It then visits each selected register, lowest index first, and makes one memory access for each. Registers whose mask bit is clear are skipped and cost no cycle. The selected registers map onto consecutive word addresses, in ascending order of register index.

For a store, the sequencer shows the register index on a register-file read port and sends the data it reads to memory. For a load, it writes the returned memory word into the register file on the cycle the memory accepts the access. It waits on a memory-ready handshake before it moves to the next register. When the list is exhausted, it pulses a done flag for one cycle. In that same cycle it can write the end address back into a chosen base register.

Top module: `lsm_seq`

## Requirements
- R1: Selected registers are visited in ascending index order, with one memory access per set mask bit (mask bit i selects register i). Clear bits produce no access. The register index is shown on `rf_raddr` during each access.
- R2: Successive accesses of one sequence use word addresses that each rise by 4 over the previous access.
- R3: With `pre_inc`=0 the first access address is `base_addr`. With `pre_inc`=1 it is `base_addr`+4.
- R4: A store (`is_load`=0) drives `mem_we`=1 and presents the `rf_rdata` value for the current index on `mem_wdata`.
- R5: A load (`is_load`=1) drives `mem_we`=0. In each cycle with `mem_ready`=1 it asserts `rf_we` with `rf_waddr` equal to the current index and `rf_wdata` equal to `mem_rdata`.
- R6: While `mem_ready`=0, the sequencer keeps `mem_req`, `mem_addr` and `rf_raddr` unchanged and writes nothing into the register file.
- R7: With `wb_en`=1, the done cycle asserts `rf_we` with `rf_waddr`=`base_idx` and `rf_wdata`=`base_addr`+4×(number of set mask bits). This writeback overrides a load into the same register. With `wb_en`=0 the done cycle writes nothing.
- R8: An empty mask makes no memory access. `done` is then high in the cycle after the start edge.
- R9: `done` is a one-cycle pulse, given in the cycle after the edge that accepts the last transfer. `busy` is high from the cycle after a start until the done cycle, inclusive. While `busy` is high, `start` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a sequence (taken only when idle) |
| mask | input | 16 | Register selection, bit i selects register i |
| base_addr | input | 32 | Base address value |
| base_idx | input | 4 | Register that receives the writeback |
| pre_inc | input | 1 | 1: step before each access, 0: step after |
| wb_en | input | 1 | Write end address back to the base register |
| is_load | input | 1 | 1: memory to registers, 0: registers to memory |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word address of the access |
| mem_wdata | output | 32 | Store data |
| mem_ready | input | 1 | Memory accepts the current access |
| mem_rdata | input | 32 | Load data, valid with mem_ready |
| rf_raddr | output | 4 | Register-file read index |
| rf_rdata | input | 32 | Register-file read data |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 4 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Sequence in progress |

## Verification
The sparse mask 0x00C3 from base 1000 checks that gaps are skipped while the addresses stay packed. The full mask and the single-bit masks at each end test the edges of the scan. The empty mask separates immediate completion from a wasted memory cycle. Each mode combination is run with `mem_ready` held high and also with random stalls, which shows whether the sequencer truly waits or just counts cycles. A load whose list contains the base register shows which write wins. Holding `start` high through a running sequence shows whether a second start can slip in.

// File: rtl/lsm_pkg.sv
// Shared types for the transfer sequencer.
package lsm_pkg;
    // Sequencer phases: idle, issuing accesses, completion/writeback cycle.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } lsm_state_e;
endpackage

// File: rtl/lsm_pick.sv
// Lowest-set-bit finder.
// Gives the index of the lowest set bit of vec, and whether any bit is set.
// Assumes NREG >= 2. idx is 0 when vec is empty.
module lsm_pick #(
    parameter int NREG  = 16,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic [NREG-1:0]  vec,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    // Scan from the top down so the lowest set bit is written last.
    always_comb begin
        idx = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end

    // Flag a non-empty vector.
    assign any = |vec;
endmodule

// File: rtl/lsm_popcnt.sv
// Population counter.
// Counts the set bits of vec. The result width holds NREG itself.
module lsm_popcnt #(
    parameter int NREG  = 16,
    localparam int CNT_W = $clog2(NREG + 1)
) (
    input  logic [NREG-1:0]  vec,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] part [NREG+1];

    assign part[0] = '0;

    // One adder stage per mask bit.
    for (genvar g = 0; g < NREG; g++) begin : g_add
        assign part[g+1] = part[g] + CNT_W'(vec[g]);
    end

    assign cnt = part[NREG];
endmodule

// File: rtl/lsm_seq.sv
// Load/store multiple transfer sequencer (top).
// Walks a register mask lowest index first and makes one word access per
// set bit at consecutive word addresses. Finishes with a one-cycle done pulse
// that may carry a base writeback. Assumes the register file read port is
// combinational and that memory samples an access on the cycle mem_ready=1.
module lsm_seq #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int NREG   = 16,
    localparam int IDX_W = $clog2(NREG),
    localparam int CNT_W = $clog2(NREG + 1),
    localparam int WORD_B = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NREG-1:0]   mask,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [IDX_W-1:0]  base_idx,
    input  logic              pre_inc,
    input  logic              wb_en,
    input  logic              is_load,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [IDX_W-1:0]  rf_raddr,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              rf_we,
    output logic [IDX_W-1:0]  rf_waddr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              done,
    output logic              busy
);
    import lsm_pkg::*;

    lsm_state_e        state;
    logic [NREG-1:0]   pend;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] end_addr;
    logic [IDX_W-1:0]  wb_idx;
    logic              wb_q;
    logic              load_q;

    logic [IDX_W-1:0]  cur_idx;
    logic              pend_any;
    logic [CNT_W-1:0]  sel_cnt;
    logic [NREG-1:0]   pend_next;
    logic              run_step;

    lsm_pick #(.NREG(NREG)) u_pick (
        .vec (pend),
        .idx (cur_idx),
        .any (pend_any)
    );

    lsm_popcnt #(.NREG(NREG)) u_cnt (
        .vec (mask),
        .cnt (sel_cnt)
    );

    // Clear the lowest pending bit once the current access is accepted.
    assign pend_next = pend & (pend - NREG'(1));
    // An access completes this cycle.
    assign run_step  = (state == ST_RUN) && mem_ready;

    // Sequencer state, pending mask and address tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            pend     <= '0;
            cur_addr <= '0;
            end_addr <= '0;
            wb_idx   <= '0;
            wb_q     <= 1'b0;
            load_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        pend     <= mask;
                        cur_addr <= pre_inc ? base_addr + ADDR_W'(WORD_B) : base_addr;
                        end_addr <= base_addr + (ADDR_W'(sel_cnt) << 2);
                        wb_idx   <= base_idx;
                        wb_q     <= wb_en;
                        load_q   <= is_load;
                        state    <= (|mask) ? ST_RUN : ST_FIN;
                    end
                end
                ST_RUN: begin
                    if (run_step) begin
                        pend     <= pend_next;
                        cur_addr <= cur_addr + ADDR_W'(WORD_B);
                        if (pend_next == '0) state <= ST_FIN;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Memory-side outputs.
    always_comb begin
        mem_req   = (state == ST_RUN) && pend_any;
        mem_we    = mem_req && !load_q;
        mem_addr  = cur_addr;
        mem_wdata = rf_rdata;
    end

    // Register-file outputs: load data in RUN, base writeback in FIN.
    always_comb begin
        rf_raddr = cur_idx;
        rf_we    = 1'b0;
        rf_waddr = cur_idx;
        rf_wdata = mem_rdata;
        if (run_step && load_q) begin
            rf_we = 1'b1;
        end else if (state == ST_FIN && wb_q) begin
            rf_we    = 1'b1;
            rf_waddr = wb_idx;
            rf_wdata = DATA_W'(end_addr);
        end
    end

    // Status.
    assign done = (state == ST_FIN);
    assign busy = (state != ST_IDLE);
endmodule

// File: rtl/lsm_seq_chk.sv
// Protocol checker for lsm_seq, bound to every instance.
// Observes ports only.
module lsm_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int NREG   = 16,
    localparam int IDX_W = $clog2(NREG)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_ready,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [IDX_W-1:0]  rf_raddr,
    input logic              rf_we,
    input logic              done,
    input logic              busy
);
    // R2: the next access address is the previous one plus 4.
    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready) |=> (!mem_req || mem_addr == $past(mem_addr) + ADDR_W'(4)));

    // R1: register indices rise strictly within a sequence.
    a_r1_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready) |=> (!mem_req || rf_raddr > $past(rf_raddr)));

    // R6: a stalled access is held unchanged.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(rf_raddr) && $stable(mem_we)));

    // R6: no register write while memory stalls.
    a_r6_no_write_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |-> !rf_we);

    // R9: done is a single-cycle pulse.
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: requests and done only happen while busy, and never together.
    a_r9_busy_cover: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || done) |-> (busy && !(mem_req && done)));

    // R5: a register write during an access only comes from an accepted load.
    a_r5_load_write: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && mem_req) |-> (mem_ready && !mem_we));
endmodule

bind lsm_seq lsm_seq_chk #(.ADDR_W(ADDR_W), .NREG(NREG)) u_chk (.*);

// File: tb/tb_lsm_seq.sv
// Bench for lsm_seq: a behavioural queue model compared every cycle.
module tb_lsm_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] mask = '0;
    logic [31:0] base_addr = '0;
    logic [3:0]  base_idx = '0;
    logic        pre_inc = 1'b0, wb_en = 1'b0, is_load = 1'b0;
    logic        mem_req, mem_we, mem_ready = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic [3:0]  rf_raddr, rf_waddr;
    logic [31:0] rf_rdata, rf_wdata;
    logic        rf_we, done, busy;

    int checks = 0, bad = 0, cyc = 0;

    // Model state.
    int          q_idx[$];
    logic [31:0] m_addr, m_end;
    logic [3:0]  m_bidx;
    bit          m_fin = 0, m_wb = 0, m_load = 0;

    always #2 clk = ~clk;

    // Register-file contents as a function of index.
    assign rf_rdata = 32'hC0DE_0000 + 32'(rf_raddr) * 32'h111;

    lsm_seq dut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // One cycle: drive inputs, check outputs, advance the model across the edge.
    task automatic step(input bit st, input int rdy_pct);
        @(negedge clk);
        start     = st;
        mem_ready = ($urandom_range(99) < rdy_pct);
        mem_rdata = $urandom;
        #1;
        chk(busy == (m_fin || q_idx.size() != 0), "R9", "busy", busy, m_fin || q_idx.size() != 0);
        if (m_fin) begin
            chk(done == 1, "R9", "done", done, 1);
            chk(mem_req == 0, "R8", "req in done", mem_req, 0);
            chk(rf_we == m_wb, "R7", "wb we", rf_we, m_wb);
            if (m_wb) begin
                chk(rf_waddr == m_bidx, "R7", "wb idx", rf_waddr, m_bidx);
                chk(rf_wdata == m_end, "R7", "wb data", rf_wdata, m_end);
            end
        end else if (q_idx.size() != 0) begin
            chk(mem_req == 1, "R1", "req", mem_req, 1);
            chk(done == 0, "R9", "done early", done, 0);
            chk(rf_raddr == 4'(q_idx[0]), "R1", "index", rf_raddr, q_idx[0]);
            chk(mem_addr == m_addr, "R2", "addr", mem_addr, m_addr);
            chk(mem_we == !m_load, "R4", "we", mem_we, !m_load);
            if (!m_load)
                chk(mem_wdata == 32'hC0DE_0000 + 32'(q_idx[0]) * 32'h111, "R4", "wdata",
                    mem_wdata, 32'hC0DE_0000 + 32'(q_idx[0]) * 32'h111);
            chk(rf_we == (m_load && mem_ready), "R6", "rf we", rf_we, m_load && mem_ready);
            if (m_load && mem_ready) begin
                chk(rf_waddr == 4'(q_idx[0]), "R5", "load idx", rf_waddr, q_idx[0]);
                chk(rf_wdata == mem_rdata, "R5", "load data", rf_wdata, mem_rdata);
            end
        end else begin
            chk(!mem_req && !done && !rf_we, "R9", "idle quiet", {mem_req, done, rf_we}, 0);
        end
        // Advance the model across the coming edge.
        if (m_fin) m_fin = 0;
        else if (q_idx.size() != 0) begin
            if (mem_ready) begin
                void'(q_idx.pop_front());
                m_addr += 4;
                if (q_idx.size() == 0) m_fin = 1;
            end
        end else if (start) begin
            int n = 0;
            for (int i = 0; i < 16; i++) if (mask[i]) begin q_idx.push_back(i); n++; end
            m_addr = pre_inc ? base_addr + 4 : base_addr;
            m_end  = base_addr + 32'(4 * n);
            m_bidx = base_idx; m_wb = wb_en; m_load = is_load;
            if (n == 0) m_fin = 1;
        end
    endtask

    task automatic run_op(input logic [15:0] mk, input logic [31:0] ba, input bit pre,
                          input bit wb, input bit ld, input logic [3:0] bi,
                          input int rdy_pct, input bit hold_start);
        @(negedge clk);
        mask = mk; base_addr = ba; pre_inc = pre; wb_en = wb; is_load = ld; base_idx = bi;
        step(1, rdy_pct);
        while (m_fin || q_idx.size() != 0) step(hold_start && q_idx.size() != 0, rdy_pct);
        step(0, rdy_pct);
    endtask

    // Watchdog: a hung run is a failure.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                bad++; checks++;
                $display("FAIL R9 watchdog act=%0d exp=<150000", cyc);
                $display("  test done: total=%0d bad=%0d", checks, bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!mem_req && !done && !busy && !rf_we, "R9", "reset state", {mem_req, done, busy, rf_we}, 0);
        rst_n = 1'b1;
        // R1 R3 sparse mask, post form, load, no stall.
        run_op(16'h00C3, 32'd1000, 0, 0, 1, 4'd10, 100, 0);
        // R3 R7 R4 pre form store with writeback and stalls.
        run_op(16'h00C3, 32'd1000, 1, 1, 0, 4'd10, 50, 0);
        // R8 empty mask with and without writeback.
        run_op(16'h0000, 32'h2000, 0, 1, 1, 4'd2, 100, 0);
        run_op(16'h0000, 32'h2000, 1, 0, 0, 4'd2, 100, 0);
        // R1 edges of the scan.
        run_op(16'hFFFF, 32'h4000, 0, 1, 1, 4'd13, 70, 0);
        run_op(16'h8000, 32'h4000, 1, 1, 0, 4'd0, 30, 0);
        run_op(16'h0001, 32'h4000, 0, 0, 1, 4'd0, 100, 0);
        // R7 base register also loaded: writeback wins.
        run_op(16'h0018, 32'h0800, 0, 1, 1, 4'd3, 60, 0);
        // R9 start held high while busy is ignored.
        run_op(16'h0A50, 32'h1234_5670, 1, 0, 0, 4'd1, 40, 1);
        // R6 heavy stalls, then random patterns.
        run_op(16'h1111, 32'h9000, 1, 1, 1, 4'd7, 10, 0);
        for (int k = 0; k < 40; k++)
            run_op(16'($urandom), {$urandom} & ~32'h3, $urandom_range(1), $urandom_range(1),
                   $urandom_range(1), 4'($urandom), 20 + $urandom_range(80), $urandom_range(1));
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule